// File: doc/BRIEF.md
# Condition Flag and Predication Unit

This block keeps the four condition flags of a 32-bit processor (negative, zero, carry, overflow) and decides, for every instruction, whether that instruction runs or is squashed. Each instruction carries a 4-bit condition field. The unit tests that field against the flags currently stored and drives `exec_o` in the same cycle. The rest of the pipeline uses `exec_o` to enable or annul the instruction.

Four operations update the flags and discard their arithmetic or logic result. Compare subtracts b from a. Compare-negate adds the operands. Test-bits ANDs them. Test-equivalence XORs them and touches only Z. The flags change at the clock edge only when the strobe is high, the condition passes and the operation sets flags. A squashed compare therefore leaves the flags alone, so a chain of conditional compares acts as a short-circuit AND.

There is no sequencing state. The only storage is the flag register. It has two behaviours, hold and load, and `load` is taken exactly when `valid_i && exec_o` holds and the operation is flag-setting.

Top module: `cond_flag_unit`

## Requirements
- R1: Compare (op 3'd1) computes a-b and writes N = bit 31 of the difference, Z = difference is zero, C = 1 when a >= b unsigned (no borrow), V = signed overflow of the subtraction.
- R2: Compare-negate (op 3'd2) computes a+b and writes N = bit 31 of the sum, Z = sum is zero, C = unsigned carry out, V = signed overflow of the addition.
- R3: Test-bits (op 3'd3) writes N = bit 31 of a AND b and Z = (a AND b) is zero, and it clears C and V.
- R4: Test-equivalence (op 3'd4) sets Z when a equals b and clears it otherwise. N, C and V keep their values.
- R5: Condition codes 0000..0111 test a single flag: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0 in that code order.
- R6: Code 1000 passes when C=1 and Z=0. Code 1001 passes when C=0 or Z=1.
- R7: Code 1010 passes when N==V. Code 1011 passes when N!=V. Code 1100 passes when Z=0 and N==V. Code 1101 passes when Z=1 or N!=V.
- R8: Code 1110 always passes and code 1111 never passes.
- R9: The flags load only when valid_i is high, the condition passes and op is 1..4. Ops 0 and 5..7, an idle cycle and a squashed instruction leave the flags unchanged.
- R10: After comparing a=0x0000006C with b=0xFFFFFFEC, code 1001 (unsigned lower or same) and code 1100 (signed greater) both pass, and code 1000 fails.
- R11: A synchronous active-high reset clears all flags. flags_o is {N,Z,C,V} with N in bit 3.
- R12: exec_o is combinational in cond_i and the stored flags. It is valid in the same cycle, with or without valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 3 | 0 none, 1 compare, 2 compare-negate, 3 test-bits, 4 test-equivalence, 5..7 none |
| cond_i | input | 4 | Instruction condition field |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |
| exec_o | output | 1 | Instruction executes (condition passes) |

## Verification
Directed patterns come first. Equal operands separate Z from C. 0x7FFFFFFF+1 and 0xFFFFFFFF+1 separate signed overflow from unsigned carry. The 0x6C/0xFFFFFFEC pair separates the unsigned predicates from the signed ones. A chained compare, compare-if-equal, test-if-equal sequence shows that a squashed compare preserves the flags. A long run of random operations, conditions and strobes follows. Its operands are biased towards equality, zero and the sign boundary so that every condition code sees both outcomes. A behavioural model is compared against exec_o and flags_o on every cycle.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_CMP  = 3'd1,
        OP_CMN  = 3'd2,
        OP_TST  = 3'd3,
        OP_TEQ  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        CC_ZS = 4'b0000, CC_ZC = 4'b0001, CC_CS = 4'b0010, CC_CC = 4'b0011,
        CC_NS = 4'b0100, CC_NC = 4'b0101, CC_VS = 4'b0110, CC_VC = 4'b0111,
        CC_UH = 4'b1000, CC_ULS = 4'b1001, CC_SGE = 4'b1010, CC_SLT = 4'b1011,
        CC_SGT = 4'b1100, CC_SLE = 4'b1101, CC_ALL = 4'b1110, CC_NONE = 4'b1111
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/cfp_flag_calc.sv
module cfp_flag_calc
    import cfp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  flags_t            cur_i,
    output flags_t            nxt_o,
    output logic              sets_o
);
    localparam int MSB = DATA_W - 1;

    logic              subtract;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] and_r;
    logic              arith_v;

    // one shared adder serves both compare flavours
    always_comb begin
        subtract = (op_e'(op_i) == OP_CMP);
        b_eff    = subtract ? ~opb_i : opb_i;
        sum_ext  = {1'b0, opa_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, subtract};
        sum      = sum_ext[MSB:0];
        and_r    = opa_i & opb_i;
        arith_v  = (opa_i[MSB] == b_eff[MSB]) && (sum[MSB] != opa_i[MSB]);
    end

    always_comb begin
        nxt_o  = cur_i;
        sets_o = 1'b1;
        unique case (op_e'(op_i))
            OP_CMP, OP_CMN: begin
                nxt_o.n = sum[MSB];
                nxt_o.z = (sum == '0);
                nxt_o.c = sum_ext[DATA_W];
                nxt_o.v = arith_v;
            end
            OP_TST: begin
                nxt_o.n = and_r[MSB];
                nxt_o.z = (and_r == '0);
                nxt_o.c = 1'b0;
                nxt_o.v = 1'b0;
            end
            OP_TEQ: begin
                nxt_o.z = ((opa_i ^ opb_i) == '0);
            end
            default: begin
                sets_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfp_cond_eval.sv
module cfp_cond_eval
    import cfp_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);
    logic sign_ok;

    always_comb begin
        sign_ok = (flags_i.n == flags_i.v);
        unique case (cond_e'(cond_i))
            CC_ZS:   pass_o = flags_i.z;
            CC_ZC:   pass_o = !flags_i.z;
            CC_CS:   pass_o = flags_i.c;
            CC_CC:   pass_o = !flags_i.c;
            CC_NS:   pass_o = flags_i.n;
            CC_NC:   pass_o = !flags_i.n;
            CC_VS:   pass_o = flags_i.v;
            CC_VC:   pass_o = !flags_i.v;
            CC_UH:   pass_o = flags_i.c && !flags_i.z;
            CC_ULS:  pass_o = !flags_i.c || flags_i.z;
            CC_SGE:  pass_o = sign_ok;
            CC_SLT:  pass_o = !sign_ok;
            CC_SGT:  pass_o = !flags_i.z && sign_ok;
            CC_SLE:  pass_o = flags_i.z || !sign_ok;
            CC_ALL:  pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [3:0]        cond_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [3:0]        flags_o,
    output logic              exec_o
);
    flags_t flags_q;
    flags_t flags_nxt;
    logic   sets_flags;
    logic   load;

    cfp_cond_eval u_eval (
        .cond_i  (cond_i),
        .flags_i (flags_q),
        .pass_o  (exec_o)
    );

    cfp_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .op_i   (op_i),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .cur_i  (flags_q),
        .nxt_o  (flags_nxt),
        .sets_o (sets_flags)
    );

    assign load = valid_i && exec_o && sets_flags;

    always_ff @(posedge clk) begin
        if (rst)       flags_q <= '0;
        else if (load) flags_q <= flags_nxt;
    end

    assign flags_o = flags_q;

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (flags_o == 4'b0000));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(flags_o));

    assert_squash_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !exec_o) |=> $stable(flags_o));

    assert_teq_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && exec_o && op_i == 3'd4) |=>
        (flags_o[3] == $past(flags_o[3]) && flags_o[1:0] == $past(flags_o[1:0])));

    assert_tst_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && exec_o && op_i == 3'd3) |=> (flags_o[1:0] == 2'b00));

    assert_always_R8: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'b1110) |-> exec_o);

    assert_never_R8: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'b1111) |-> !exec_o);

endmodule

// File: tb/test_cond_flag_unit.sv
`timescale 1ns/1ps
module test_cond_flag_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  op_i;
    logic [3:0]  cond_i;
    logic [31:0] opa_i;
    logic [31:0] opb_i;
    logic [3:0]  flags_o;
    logic        exec_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] ref_f;
    string last_req = "R11";

    always #4 clk = ~clk;

    cond_flag_unit i_cond_flag_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .cond_i(cond_i),
        .opa_i(opa_i), .opb_i(opb_i), .flags_o(flags_o), .exec_o(exec_o)
    );

    // behavioural model: flags are {N,Z,C,V}
    function automatic bit ref_pass(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;        1: return !z;
            2: return cy;       3: return !cy;
            4: return n;        5: return !n;
            6: return v;        7: return !v;
            8: return cy && !z; 9: return !cy || z;
            10: return n == v;  11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] ref_next(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [3:0] f);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint sr;
        longint unsigned ur;
        logic [31:0] r;
        logic [3:0] o = f;
        case (op)
            1: begin
                r = a - b; sr = sa - sb;
                o = {r[31], a == b, a >= b, (sr > 64'sd2147483647) || (sr < -64'sd2147483648)};
            end
            2: begin
                r = a + b; sr = sa + sb;
                ur = longint'(a) + longint'(b);
                o = {r[31], r == 0, ur > 64'hFFFF_FFFF,
                     (sr > 64'sd2147483647) || (sr < -64'sd2147483648)};
            end
            3: begin
                r = a & b;
                o = {r[31], r == 0, 1'b0, 1'b0};
            end
            4: o[2] = (a == b);
            default: o = f;
        endcase
        return o;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [3:0] c,
                        input logic [31:0] a, input logic [31:0] b, input string req);
        bit p;
        @(negedge clk);
        check(flags_o === ref_f, last_req, "flags", {28'b0, flags_o}, {28'b0, ref_f});
        valid_i = v; op_i = op; cond_i = c; opa_i = a; opb_i = b;
        #1;
        p = ref_pass(c, ref_f);
        check(exec_o === p, "R12", {req, " exec"}, {31'b0, exec_o}, {31'b0, p});
        if (v && p) ref_f = ref_next(op, a, b, ref_f);
        last_req = req;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h0;
            1: return 32'h8000_0000;
            2: return 32'h7FFF_FFFF;
            3: return 32'hFFFF_FFFF;
            4: return 32'($urandom_range(0, 3));
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_i = 0; op_i = 0; cond_i = 4'b1110; opa_i = 0; opb_i = 0;
        ref_f = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R11 reset state, R8 always/never
        step(0, 0, 4'b1110, 0, 0, "R8");
        step(0, 0, 4'b1111, 0, 0, "R8");
        step(0, 0, 4'b0001, 0, 0, "R11");
        // R1 equal compare
        step(1, 1, 4'b1110, 5, 5, "R1");
        step(0, 0, 4'b0000, 0, 0, "R5");
        step(0, 0, 4'b0010, 0, 0, "R5");
        // R4 only Z changes
        step(1, 4, 4'b1110, 1, 2, "R4");
        step(1, 4, 4'b1110, 32'hABCD, 32'hABCD, "R4");
        // R3 test-bits
        step(1, 3, 4'b1110, 32'h8000_0000, 32'hF000_0000, "R3");
        step(0, 0, 4'b0100, 0, 0, "R5");
        // R2 compare-negate overflow and carry
        step(1, 2, 4'b1110, 32'h7FFF_FFFF, 1, "R2");
        step(0, 0, 4'b0110, 0, 0, "R5");
        step(1, 2, 4'b1110, 32'hFFFF_FFFF, 1, "R2");
        step(0, 0, 4'b1000, 0, 0, "R6");
        // R9 squashed, idle and non-flag ops keep flags
        step(1, 1, 4'b1111, 3, 9, "R9");
        step(0, 1, 4'b1110, 3, 9, "R9");
        step(1, 5, 4'b1110, 3, 9, "R9");
        step(1, 0, 4'b1110, 3, 9, "R9");
        // R9 chained compare: both equal, then second unequal
        step(1, 1, 4'b1110, 1, 1, "R9");
        step(1, 1, 4'b0000, 2, 3, "R9");
        step(0, 0, 4'b0000, 0, 0, "R9");
        step(1, 1, 4'b1110, 1, 2, "R9");
        step(1, 1, 4'b0000, 3, 3, "R9");
        step(0, 0, 4'b0000, 0, 0, "R9");
        // R10 signed vs unsigned
        step(1, 1, 4'b1110, 32'h6C, 32'hFFFF_FFEC, "R10");
        step(0, 0, 4'b1001, 0, 0, "R10");
        step(0, 0, 4'b1100, 0, 0, "R10");
        step(0, 0, 4'b1000, 0, 0, "R10");
        step(0, 0, 4'b1010, 0, 0, "R7");
        // random mix across all codes
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
                 4'($urandom_range(0, 15)), pick(), pick(), "R1 R2 R6 R7");
        end
        step(0, 0, 4'b1110, 0, 0, "R7");
        // R11 reset again clears flags
        @(negedge clk); rst = 1'b1; ref_f = 4'b0000;
        @(negedge clk); rst = 1'b0;
        last_req = "R11";
        step(0, 0, 4'b1110, 0, 0, "R11");
        step(0, 0, 4'b1110, 0, 0, "R11");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule